// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches the first byte a target receives after a START or repeated START condition. It compares that byte against a programmable 7-bit own address. When its enable input is set, it also compares the byte against the general call address. Byte assembly happens elsewhere. The matcher receives:

- event pulses: `start_det`, `stop_det` and `byte_valid`;
- the assembled byte, `rx_byte`, with the address in bits [7:1] and the read/write bit in bit [0];
- a level, `ninth_slot`, that is high during the acknowledge clock.

On a hit the block produces four results:

- a one-cycle `addr_match` pulse;
- a `gen_call` flag;
- the received `rw_bit`;
- a `wake_req` pulse whenever the host is asleep.

It also decides whether to pull SDA low in the ninth clock. It does so only when the byte matched and the host allowed acknowledgement. Its small clock domain keeps running while the host is asleep, so an incoming transfer can wake the host.

The controller has five named states:

- `ST_IDLE`: not addressed.
- `ST_ADDR`: waiting for the address byte.
- `ST_ACK_WAIT`: matched, waiting for the ninth clock.
- `ST_ACK_DRIVE`: in the ninth clock.
- `ST_DATA`: addressed, later bytes ignored.

The transitions are:

- `start_det` from any state goes to `ST_ADDR`. This has the highest priority.
- `stop_det` from any state goes to `ST_IDLE`.
- `ST_ADDR` with `byte_valid` goes to `ST_ACK_WAIT` on a hit and to `ST_IDLE` on a miss.
- `ST_ACK_WAIT` with `ninth_slot` high goes to `ST_ACK_DRIVE`.
- `ST_ACK_DRIVE` with `ninth_slot` low goes to `ST_DATA`.
- `ST_IDLE` and `ST_DATA` hold until a START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `addr_match`, `gen_call`, `rw_bit`, `wake_req` and `sda_pull` are all 0.
- R2: A byte with `rx_byte[7:1]` equal to `own_addr` arriving as the first byte after a START gives `addr_match`=1 for exactly one cycle, starting in the cycle after the edge that samples `byte_valid`. In the same cycle `rw_bit` equals `rx_byte[0]` and `gen_call` is 0.
- R3: With `gc_en`=1, `rx_byte`=8'h00 matches with `gen_call`=1. The bytes 8'h01 (read), and 8'h00 with `gc_en`=0, do not match unless they equal the own address.
- R4: Only the first byte after a START or repeated START is compared. Later bytes give no `addr_match`, and a repeated START re-arms the comparison.
- R5: A STOP returns the block to idle, so a byte that follows a STOP without a new START gives no `addr_match`.
- R6: After a match taken with `ack_en`=1 (sampled with `byte_valid`), `sda_pull` is 1 from the cycle after `ninth_slot` is first sampled high until the edge that samples it low. With `ack_en`=0 it stays 0.
- R7: A byte that does not match leaves `sda_pull` at 0 through the following ninth clock.
- R8: `wake_req` pulses together with `addr_match` when `host_sleep` is 1, and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on matcher clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | Pulse: START or repeated START seen |
| stop_det | input | 1 | Pulse: STOP seen |
| byte_valid | input | 1 | Pulse: `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte: address in [7:1], R/W in [0] |
| ninth_slot | input | 1 | High during the acknowledge clock |
| own_addr | input | 7 | Programmed own address |
| gc_en | input | 1 | Enable general call recognition |
| ack_en | input | 1 | Host permits acknowledging a match |
| host_sleep | input | 1 | Host is asleep |
| addr_match | output | 1 | One-cycle pulse on a match |
| gen_call | output | 1 | Last match was a general call |
| rw_bit | output | 1 | R/W bit of the last match |
| wake_req | output | 1 | Pulse: match while host asleep |
| sda_pull | output | 1 | Pull SDA low (ACK) |

## Verification
The bench builds the block with its defaults: `ADDR_W`=7 and `GC_SUPPORT`=1. This keeps the general call comparator present, so both sides of the R3 filter are in reach. The filter accepts only the all-zero write byte, and only when it is enabled. A table of own addresses, enables and bytes exercises hits, misses and edge addresses. Directed sequences then probe four cases:

- data bytes after a match;
- repeated START re-arming;
- a byte after STOP;
- the ninth-clock window with acknowledge on and off.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_DATA
    } am_state_t;
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int ADDR_W     = 7,
    parameter bit GC_SUPPORT = 1'b1
) (
    input  logic [ADDR_W:0]   rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    output logic              own_hit,
    output logic              gc_hit,
    output logic              rw
);
    logic [ADDR_W-1:0] addr_field;

    assign addr_field = rx_byte[ADDR_W:1];
    assign rw         = rx_byte[0];
    assign own_hit    = (addr_field == own_addr);

    generate
        if (GC_SUPPORT) begin : g_gc
            assign gc_hit = gc_en && (addr_field == '0) && !rw;
        end else begin : g_no_gc
            assign gc_hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
    import i2c_am_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic byte_valid,
    input  logic ninth_slot,
    input  logic own_hit,
    input  logic gc_hit,
    input  logic rw_in,
    input  logic ack_en,
    input  logic host_sleep,
    output logic match_o,
    output logic gc_o,
    output logic rw_o,
    output logic wake_o,
    output logic sda_pull_o
);
    am_state_t state_q, state_d;
    logic      ack_q;
    logic      take;

    assign take = (state_q == ST_ADDR) && byte_valid && !start_det && !stop_det
                  && (own_hit || gc_hit);

    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_valid) state_d = (own_hit || gc_hit) ? ST_ACK_WAIT : ST_IDLE;
                ST_ACK_WAIT:  if (ninth_slot) state_d = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (!ninth_slot) state_d = ST_DATA;
                ST_DATA:      state_d = ST_DATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            gc_o    <= 1'b0;
            rw_o    <= 1'b0;
            wake_o  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            match_o <= take;
            wake_o  <= take && host_sleep;
            if (take) begin
                gc_o  <= gc_hit;
                rw_o  <= rw_in;
                ack_q <= ack_en;
            end
        end
    end

    assign sda_pull_o = (state_q == ST_ACK_DRIVE) && ack_q;

    // R2: a match is a single-cycle pulse
    p_match_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    // R2: a match only follows a sampled byte
    p_match_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(byte_valid));
    // R6: acknowledge only inside the ninth clock
    p_pull_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> $past(ninth_slot));
    // R8: wake only with a match
    p_wake_with_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> match_o);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W     = 7,
    parameter bit GC_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_valid,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              ninth_slot,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              host_sleep,
    output logic              addr_match,
    output logic              gen_call,
    output logic              rw_bit,
    output logic              wake_req,
    output logic              sda_pull
);
    logic own_hit, gc_hit, rw_in;

    i2c_am_cmp #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
        .rx_byte  (rx_byte),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .own_hit  (own_hit),
        .gc_hit   (gc_hit),
        .rw       (rw_in)
    );

    i2c_am_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .byte_valid (byte_valid),
        .ninth_slot (ninth_slot),
        .own_hit    (own_hit),
        .gc_hit     (gc_hit),
        .rw_in      (rw_in),
        .ack_en     (ack_en),
        .host_sleep (host_sleep),
        .match_o    (addr_match),
        .gc_o       (gen_call),
        .rw_o       (rw_bit),
        .wake_o     (wake_req),
        .sda_pull_o (sda_pull)
    );

    // R3: a general call is never a read
    p_gc_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_match && gen_call) |-> !rw_bit);
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_det = 0, stop_det = 0, byte_valid = 0, ninth_slot = 0;
    logic [7:0] rx_byte = '0;
    logic [6:0] own_addr = '0;
    logic gc_en = 0, ack_en = 0, host_sleep = 0;
    logic addr_match, gen_call, rw_bit, wake_req, sda_pull;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    i2c_addr_match u_dut (.*);

    // {own[20:14], gc_en[13], ack_en[12], sleep[11], byte[10:3], match[2], gc[1], wake[0]}
    localparam logic [20:0] VEC [8] = '{
        {7'h50, 1'b1, 1'b1, 1'b0, 8'hA0, 1'b1, 1'b0, 1'b0},
        {7'h50, 1'b1, 1'b1, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b1},
        {7'h50, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
        {7'h50, 1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
        {7'h50, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {7'h50, 1'b0, 1'b0, 1'b0, 8'hA0, 1'b1, 1'b0, 1'b0},
        {7'h3F, 1'b0, 1'b1, 1'b0, 8'h7E, 1'b1, 1'b0, 1'b0},
        {7'h3F, 1'b1, 1'b1, 1'b0, 8'hA0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_det = 1;
        @(negedge clk) start_det = 0;
    endtask

    // drives a byte; returns after the edge that sampled it
    task automatic send_byte(input logic [7:0] b);
        rx_byte = b; byte_valid = 1;
        @(negedge clk) byte_valid = 0;
    endtask

    task automatic ninth(input logic exp_pull, input string tag);
        ninth_slot = 1;
        @(negedge clk) chk(sda_pull, exp_pull, {tag, " ack drive"});
        @(negedge clk) chk(sda_pull, exp_pull, {tag, " ack held"});
        ninth_slot = 0;
        @(negedge clk) chk(sda_pull, 1'b0, {tag, " ack released"});
    endtask

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(addr_match, 0, "R1 match"); chk(gen_call, 0, "R1 gc");
        chk(rw_bit, 0, "R1 rw"); chk(wake_req, 0, "R1 wake"); chk(sda_pull, 0, "R1 sda");
        rst_n = 1;

        foreach (VEC[i]) begin
            logic [20:0] v;
            v = VEC[i];
            own_addr = v[20:14]; gc_en = v[13]; ack_en = v[12]; host_sleep = v[11];
            pulse_start();
            send_byte(v[10:3]);
            chk(addr_match, v[2], $sformatf("R2/R3 match vec%0d", i));
            chk(wake_req, v[0], $sformatf("R8 wake vec%0d", i));
            if (v[2]) begin
                chk(gen_call, v[1], $sformatf("R3 gc vec%0d", i));
                chk(rw_bit, v[3], $sformatf("R2 rw vec%0d", i));
            end
            @(negedge clk) chk(addr_match, 0, $sformatf("R2 pulse end vec%0d", i));
            ninth(v[2] && v[12], v[2] ? "R6" : "R7");
            @(negedge clk) stop_det = 1;
            @(negedge clk) stop_det = 0;
        end

        // R4: data bytes after a match are ignored, repeated START re-arms
        own_addr = 7'h22; gc_en = 1; ack_en = 1; host_sleep = 0;
        pulse_start();
        send_byte(8'h44);
        chk(addr_match, 1, "R4 first byte");
        ninth(1'b1, "R6 r4seq");
        send_byte(8'h44);
        chk(addr_match, 0, "R4 data byte ignored");
        ninth(1'b0, "R4 data no ack");
        pulse_start();
        send_byte(8'h45);
        chk(addr_match, 1, "R4 repeated start");
        chk(rw_bit, 1, "R4 rw read");

        // R5: byte after STOP without START
        @(negedge clk) stop_det = 1;
        @(negedge clk) stop_det = 0;
        send_byte(8'h44);
        chk(addr_match, 0, "R5 after stop");
        ninth(1'b0, "R5 no ack");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule